// File: doc/BRIEF.md
# 100BASE-X Carrier Sense Detector

This block decides, bit by bit, whether the receive side of a 100 Mb/s link carries a frame. It sees the 5-bit-coded receive stream after descrambling, one bit per clock enable, with the earliest bit of each code group arriving first. Two zeros that are not next to each other within a short window raise a tentative carrier. A start-of-stream delimiter (the code group pair J then K) confirms it and fixes where symbols begin. A run of ones that arrives first withdraws it. A confirmed carrier stays up until the stream ends with a T then R pair or with two IDLE groups in a row.

The registered carrier output also folds in local transmit activity. When the port runs half duplex and not as a repeater, transmit enable also drives carrier sense. In full-duplex or repeater mode only receive activity counts. The block is meant to sit between the symbol-level receive path and the MAC-facing carrier sense pin.

Top module: `carrier_sense_detector`

## Requirements
- R1: After reset, with transmit enable low, `crs` is 0 and stays 0 while only ones are received.
- R2: With no carrier, `crs` goes to 1 at the clock edge that takes the bit which completes, within the last 10 received bits, two zeros at least two positions apart. Adjacent zeros alone never raise it.
- R3: In the tentative phase, before a start delimiter, `crs` falls to 0 at the edge that takes the tenth consecutive one.
- R4: The 10-bit sequence 1100010001 (J = 11000 then K = 10001, leftmost bit first) confirms carrier. From then on, symbols are taken in 5-bit groups starting after K, and runs of ones no longer drop carrier.
- R5: A confirmed carrier falls to 0 at the edge that takes the last bit of R (00111) when R directly follows T (01101).
- R6: A confirmed carrier falls to 0 at the edge that takes the last bit of an IDLE group (11111) that directly follows another IDLE group.
- R7: T followed by any group other than R, or IDLE followed by any non-IDLE group, leaves `crs` at 1.
- R8: `crs` equals (receive activity) OR (`txEn` AND NOT (`fullDuplex` OR `repeaterMode`)), with a delay of one clock.
- R9: Receive state moves only on cycles with `bitValid` high. Bits presented without it are ignored.
- R10: After an end of stream, the bit history is treated as all ones, so the zeros of T and R do not retrigger carrier, and a following J K starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | Qualifies `rxBit` for this cycle |
| rxBit | input | 1 | Unscrambled coded receive bit |
| txEn | input | 1 | Local transmit activity |
| fullDuplex | input | 1 | Full-duplex mode |
| repeaterMode | input | 1 | Repeater mode |
| crs | output | 1 | Registered carrier sense |

## Verification
On every cycle, the assertions check the transmit fold, that state holds when no bit is qualified, and that the receive state enters the confirmed phase only on a J K match. They also check that it leaves the confirmed phase only on a completed end pair and leaves the tentative phase when the ones run hits its limit. Some behaviour only the bench scenarios can show. These are the exact bit at which carrier rises for each 10-bit pattern (swept over all 1024), the lookahead cases where a T or IDLE is not followed by its partner, and back-to-back frames after a history clear.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int SYM_W = 5;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;

  typedef enum logic [1:0] {ST_IDLE, ST_TENT, ST_CONF} csState_t;

  typedef struct packed {
    logic clearHist;
    logic startAlign;
  } csStrobe_t;
endpackage

// File: rtl/csd_datapath.sv
module csd_datapath
  import csd_pkg::*;
#(
  parameter int WIN_LEN    = 10,
  parameter int ONES_LIMIT = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitValid,
  input  logic      rxBit,
  input  csStrobe_t strobe,
  output logic      trigHit,
  output logic      jkHit,
  output logic      onesRun,
  output logic      endPair
);
  localparam int CNT_W = $clog2(ONES_LIMIT + 1);
  localparam int SC_W  = $clog2(SYM_W);

  logic [WIN_LEN-1:0] hist, histN;
  logic [CNT_W-1:0]   onesCnt;
  logic [SYM_W-1:0]   symSr, prevSym, curSym;
  logic [SC_W-1:0]    symCnt;
  logic               pairHit, symDone;

  assign histN = {hist[WIN_LEN-2:0], rxBit};

  always_comb begin
    pairHit = 1'b0;
    for (int i = 0; i < WIN_LEN; i++) begin
      for (int j = i + 2; j < WIN_LEN; j++) begin
        if (!histN[i] && !histN[j]) pairHit = 1'b1;
      end
    end
  end

  assign curSym  = {symSr[SYM_W-2:0], rxBit};
  assign symDone = bitValid && (symCnt == SC_W'(SYM_W - 1));
  assign trigHit = bitValid && pairHit;
  assign jkHit   = bitValid && (histN[2*SYM_W-1:0] == {CG_J, CG_K});
  assign onesRun = bitValid && rxBit && (onesCnt == CNT_W'(ONES_LIMIT - 1));
  assign endPair = symDone && (((prevSym == CG_T) && (curSym == CG_R)) ||
                               ((prevSym == CG_IDLE) && (curSym == CG_IDLE)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist    <= '1;
      onesCnt <= '0;
      symSr   <= '1;
      prevSym <= CG_K;
      symCnt  <= '0;
    end else if (bitValid) begin
      hist  <= strobe.clearHist ? '1 : histN;
      symSr <= curSym;
      if (!rxBit) onesCnt <= '0;
      else if (onesCnt != CNT_W'(ONES_LIMIT)) onesCnt <= onesCnt + 1'b1;
      if (strobe.startAlign) begin
        symCnt  <= '0;
        prevSym <= CG_K;
      end else if (symDone) begin
        symCnt  <= '0;
        prevSym <= curSym;
      end else begin
        symCnt <= symCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csd_control.sv
module csd_control
  import csd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitValid,
  input  logic      trigHit,
  input  logic      jkHit,
  input  logic      onesRun,
  input  logic      endPair,
  input  logic      txEn,
  input  logic      fullDuplex,
  input  logic      repeaterMode,
  output csStrobe_t strobe,
  output csState_t  stateQ,
  output logic      crs
);
  csState_t stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (bitValid) begin
      unique case (stateQ)
        ST_IDLE: begin
          if (jkHit) begin
            stateD = ST_CONF;
            strobe.startAlign = 1'b1;
          end else if (trigHit) begin
            stateD = ST_TENT;
          end
        end
        ST_TENT: begin
          if (jkHit) begin
            stateD = ST_CONF;
            strobe.startAlign = 1'b1;
          end else if (onesRun) begin
            stateD = ST_IDLE;
          end
        end
        ST_CONF: begin
          if (endPair) begin
            stateD = ST_IDLE;
            strobe.clearHist = 1'b1;
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      crs    <= 1'b0;
    end else begin
      stateQ <= stateD;
      crs    <= (stateD != ST_IDLE) || (txEn && !(fullDuplex || repeaterMode));
    end
  end
endmodule

// File: rtl/carrier_sense_detector.sv
module carrier_sense_detector
  import csd_pkg::*;
#(
  parameter int WIN_LEN    = 10,
  parameter int ONES_LIMIT = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic rxBit,
  input  logic txEn,
  input  logic fullDuplex,
  input  logic repeaterMode,
  output logic crs
);
  csStrobe_t strobe;
  csState_t  stateQ;
  logic      trigHit, jkHit, onesRun, endPair;

  csd_datapath #(.WIN_LEN(WIN_LEN), .ONES_LIMIT(ONES_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .strobe(strobe), .trigHit(trigHit), .jkHit(jkHit),
    .onesRun(onesRun), .endPair(endPair)
  );

  csd_control u_ctl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .trigHit(trigHit),
    .jkHit(jkHit), .onesRun(onesRun), .endPair(endPair), .txEn(txEn),
    .fullDuplex(fullDuplex), .repeaterMode(repeaterMode),
    .strobe(strobe), .stateQ(stateQ), .crs(crs)
  );
endmodule

// File: rtl/csd_checker.sv
module csd_checker
  import csd_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     bitValid,
  input logic     txEn,
  input logic     fullDuplex,
  input logic     repeaterMode,
  input logic     crs,
  input csState_t stateQ,
  input logic     jkHit,
  input logic     onesRun,
  input logic     endPair
);
  AST_TX_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !fullDuplex && !repeaterMode) |=> crs); // R8

  AST_HOLD_WITHOUT_BIT: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(stateQ)); // R9

  AST_CONFIRM_ON_JK: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CONF && $past(stateQ) != ST_CONF) |-> $past(jkHit)); // R4

  AST_EXIT_ON_END_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_CONF && stateQ != ST_CONF) |-> $past(endPair)); // R5

  AST_ONES_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_TENT && onesRun && !jkHit) |=> stateQ == ST_IDLE); // R3
endmodule

bind carrier_sense_detector csd_checker u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .txEn(txEn),
  .fullDuplex(fullDuplex), .repeaterMode(repeaterMode), .crs(crs),
  .stateQ(stateQ), .jkHit(jkHit), .onesRun(onesRun), .endPair(endPair)
);

// File: tb/sim_carrier_sense_detector.sv
`timescale 1ns/1ps
module sim_carrier_sense_detector;
  logic clk = 1'b0, rstN = 1'b0, bitValid = 1'b0, rxBit = 1'b1;
  logic txEn = 1'b0, fullDuplex = 1'b0, repeaterMode = 1'b0;
  logic crs;
  int nChecks = 0, nFails = 0;

  localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                         R = 5'b00111, I = 5'b11111, D = 5'b01010;

  always #10 clk = ~clk;

  carrier_sense_detector u0 (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit), .txEn(txEn),
    .fullDuplex(fullDuplex), .repeaterMode(repeaterMode), .crs(crs)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s crs actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; bitValid = 1'b0; rxBit = 1'b1;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendBit(input logic b);
    rxBit = b; bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic sendSym(input logic [4:0] s);
    for (int k = 4; k >= 0; k--) sendBit(s[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    chk("R1 reset", crs, 1'b0);
    repeat (3) sendSym(I);
    chk("R1 ones only", crs, 1'b0);

    // R2 sweep: every 10-bit pattern from an all-ones history
    for (int p = 0; p < 1024; p++) begin
      int firstZero;
      logic expHit;
      doReset();
      firstZero = -1; expHit = 1'b0;
      for (int k = 0; k < 10; k++) begin
        logic b;
        b = p[9-k];
        sendBit(b);
        if (!b) begin
          if (firstZero < 0) firstZero = k;
          else if (k >= firstZero + 2) expHit = 1'b1;
        end
        chk("R2 trigger sweep", crs, expHit);
      end
    end

    // R3 false start
    doReset();
    sendBit(0); chk("R2 single zero", crs, 1'b0);
    sendBit(1); sendBit(0); chk("R2 spaced zeros", crs, 1'b1);
    for (int k = 0; k < 9; k++) sendBit(1);
    chk("R3 nine ones hold", crs, 1'b1);
    sendBit(1); chk("R3 tenth one drops", crs, 1'b0);
    sendSym(I); chk("R3 stays low", crs, 1'b0);

    // Full frame R4..R7, R10
    doReset();
    sendSym(I); sendSym(J); chk("R2 raised by J", crs, 1'b1);
    sendSym(K); chk("R4 confirmed", crs, 1'b1);
    sendSym(5'b01111); sendSym(I); sendSym(5'b11110);
    chk("R4 ones run ignored, R7 idle then data", crs, 1'b1);
    sendSym(T); sendSym(D); chk("R7 T then data", crs, 1'b1);
    sendSym(T);
    for (int k = 4; k >= 1; k--) sendBit(R[k]);
    chk("R5 before last R bit", crs, 1'b1);
    sendBit(R[0]); chk("R5 end at R", crs, 1'b0);
    repeat (3) sendSym(I);
    chk("R10 no retrigger", crs, 1'b0);
    sendSym(J); sendSym(K); chk("R10 back-to-back start", crs, 1'b1);
    sendSym(D); sendSym(I);
    for (int k = 4; k >= 1; k--) sendBit(I[k]);
    chk("R6 before last idle bit", crs, 1'b1);
    sendBit(I[0]); chk("R6 end at idle pair", crs, 1'b0);

    // R9 gating
    rxBit = 1'b0;
    repeat (20) begin @(negedge clk); rxBit = ~rxBit; end
    chk("R9 idle ignored bits", crs, 1'b0);
    sendBit(1); chk("R9 history untouched", crs, 1'b0);
    sendSym(J); sendSym(K);
    rxBit = 1'b0;
    repeat (12) begin @(negedge clk); rxBit = ~rxBit; end
    sendSym(I); sendSym(I); chk("R9 alignment kept", crs, 1'b0);

    // R8 mode fold, idle and active
    for (int m = 0; m < 8; m++) begin
      txEn = m[0]; fullDuplex = m[1]; repeaterMode = m[2];
      @(negedge clk); @(negedge clk);
      chk("R8 idle fold", crs, m[0] & ~(m[1] | m[2]));
    end
    txEn = 1'b0; fullDuplex = 1'b0; repeaterMode = 1'b0;
    sendSym(J); sendSym(K);
    for (int m = 0; m < 8; m++) begin
      txEn = m[0]; fullDuplex = m[1]; repeaterMode = m[2];
      @(negedge clk); @(negedge clk);
      chk("R8 active fold", crs, 1'b1);
    end
    txEn = 1'b0;
    sendSym(T); sendSym(R); chk("R8 rx only after end", crs, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule